// File: doc/BRIEF.md
# Command-Driven Configuration Port Loader

This block feeds configuration bytes into the 8-bit parallel configuration port of a programmable device. A host steers it with short commands. The host can set a first and a last flash address and a byte count. It can then start a transfer, either from flash or byte by byte from the host data stream. The loader never looks inside the bytes, because every device-level command travels inside the stream itself. Toward the device it drives a data byte, a write strobe, a chip select and a configuration clock. The clock pulses only for a byte that is ready, so bytes may arrive at any uneven rate.

Flash is a shared resource. The loader raises a request and waits until the owner code on the flash side names it. Only then does it issue an address with a one-cycle read command, and it takes the byte when flash data-valid is high. A scrub command reads the same address range again and again, with a programmable idle gap between passes, until an abort stops it. Commands and host bytes arrive on valid/ready channels. A command is taken only when `cmd_ready` is high, and `cmd_ready` stays low while a transfer is running unless the command offered is an abort. A host byte is taken on a cycle where `hd_valid` and `hd_ready` are both high. The host holds the byte until then. The flash side and the device port carry no back-pressure.

Top module: `cfgport_loader`

## Requirements
- R1: After reset, `busy`, `cfg_cs`, `cfg_wr`, `cfg_clk`, `fl_req` and `hd_ready` are low and `cmd_ready` is high.
- R2: Command codes on `cmd_op` are: 0 set first flash address, 1 set last flash address, 2 run from flash, 3 set byte count, 4 run from host, 5 scrub (argument is the gap period), 6 abort, 7 reserved. Code 7 is accepted and changes no stored setting and starts nothing.
- R3: Run from flash delivers, in ascending order, the byte of every address from first to last inclusive, one byte per address. If last is below first, exactly the byte at the first address is delivered.
- R4: Before any flash read the loader holds `fl_req` high. It pulses `fl_rd` for one cycle with `fl_addr` only while `fl_owner` equals its own ID parameter, and it takes `fl_data` on a cycle with `fl_dvalid` high.
- R5: `fl_req` falls on the cycle after the last byte of a flash pass has been handed to the port.
- R6: Run from host accepts exactly the stored byte count on the host channel, then holds `hd_ready` low. A count of 0 starts nothing, and `busy` stays low.
- R7: `cfg_clk` goes high for exactly one cycle per delivered byte, with `cfg_data` already stable on the cycle before. It never pulses without a byte, whatever the gaps between bytes.
- R8: `cfg_cs` and `cfg_wr` are high from the start of a transfer until its last byte is clocked. They are high on every clock pulse and low while idle and during the gap between scrub passes.
- R9: Scrub repeats the first-to-last flash pass after an idle gap longer than the period argument in cycles, until aborted.
- R10: An abort (code 6) is accepted in any state. On the next cycle `cfg_cs`, `cfg_wr`, `cfg_clk`, `fl_req` and `busy` are low and no further clock pulse follows.
- R11: `busy` is high from acceptance of a run or scrub command until the last byte has been clocked. While busy, `cmd_ready` is low for any command other than abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when both high |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_arg | input | ARG_W | Address, count or period argument |
| hd_valid | input | 1 | Host byte offered |
| hd_ready | output | 1 | Host byte accepted when both high |
| hd_data | input | DW | Host byte |
| fl_req | output | 1 | Flash access request |
| fl_owner | input | OW | Code of the current flash owner |
| fl_addr | output | ARG_W | Flash read address |
| fl_rd | output | 1 | One-cycle flash read command |
| fl_data | input | DW | Flash read byte |
| fl_dvalid | input | 1 | Flash read byte valid |
| cfg_data | output | DW | Configuration data byte |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_cs | output | 1 | Configuration chip select |
| cfg_clk | output | 1 | Gated configuration clock |
| busy | output | 1 | Transfer or scrub in progress |

## Verification
The bench builds the loader with an 8-bit argument width, a 2-bit owner code and an ID of 2. Its flash model shows owner code 1 while the request is pending, so any read issued before the grant is caught at once. The narrow argument keeps address ranges, counts and a scrub period of 20 small enough that several full scrub passes, the gap between them and an abort in mid-pass all fit in a short run. The flash model also varies its read latency with the address, and the host sends with uneven gaps, so the clock gating is exercised against irregular delivery.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    OP_SET_FIRST = 3'd0,
    OP_SET_LAST  = 3'd1,
    OP_RUN_FLASH = 3'd2,
    OP_SET_COUNT = 3'd3,
    OP_RUN_HOST  = 3'd4,
    OP_RUN_SCRUB = 3'd5,
    OP_ABORT     = 3'd6,
    OP_RSVD      = 3'd7
  } op_e;

  typedef enum logic [2:0] {T_IDLE, T_FLASH, T_HOST, T_DRAIN, T_GAP} top_st_e;
  typedef enum logic [2:0] {F_IDLE, F_REQ, F_ISSUE, F_WAIT, F_HOLD} fl_st_e;
  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_HIGH} port_st_e;
endpackage

// File: rtl/cfgld_flash_rd.sv
module cfgld_flash_rd import cfgld_pkg::*; #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int OW    = 2,
  parameter int MY_ID = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic          fl_req,
  input  logic [OW-1:0] fl_owner,
  output logic [AW-1:0] fl_addr,
  output logic          fl_rd,
  input  logic [DW-1:0] fl_data,
  input  logic          fl_dvalid,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          done
);
  localparam logic [OW-1:0] ID_CODE = OW'(MY_ID);

  fl_st_e        st;
  logic [AW-1:0] cur, stop_q;
  logic [DW-1:0] byte_q;
  logic          at_end;

  assign at_end    = (cur >= stop_q);
  assign fl_req    = (st != F_IDLE);
  assign fl_rd     = (st == F_ISSUE);
  assign fl_addr   = cur;
  assign out_valid = (st == F_HOLD);
  assign out_data  = byte_q;
  assign done      = out_valid && out_ready && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      cur    <= '0;
      stop_q <= '0;
      byte_q <= '0;
    end else if (abort) begin
      st <= F_IDLE;
    end else begin
      case (st)
        F_IDLE:  if (start) begin
                   cur    <= first_addr;
                   stop_q <= last_addr;
                   st     <= F_REQ;
                 end
        F_REQ:   if (fl_owner == ID_CODE) st <= F_ISSUE;
        F_ISSUE: st <= F_WAIT;
        F_WAIT:  if (fl_dvalid) begin
                   byte_q <= fl_data;
                   st     <= F_HOLD;
                 end
        F_HOLD:  if (out_ready) begin
                   if (at_end) st <= F_IDLE;
                   else begin
                     cur <= cur + 1'b1;
                     st  <= F_ISSUE;
                   end
                 end
        default: st <= F_IDLE;
      endcase
    end
  end

  AST_READ_ONLY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> (fl_owner == ID_CODE)); // R4
  AST_REQ_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> fl_req); // R4
  AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !fl_req); // R5
endmodule

// File: rtl/cfgld_port_drv.sv
module cfgld_port_drv import cfgld_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] cfg_data,
  output logic          cfg_clk,
  output logic          idle
);
  port_st_e      st;
  logic [DW-1:0] data_q;
  logic          take;

  assign in_ready = (st != P_SETUP) && !flush;
  assign take     = in_valid && in_ready;
  assign cfg_data = data_q;
  assign cfg_clk  = (st == P_HIGH);
  assign idle     = (st == P_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= P_IDLE;
      data_q <= '0;
    end else if (flush) begin
      st <= P_IDLE;
    end else begin
      case (st)
        P_IDLE:  if (take) begin
                   data_q <= in_data;
                   st     <= P_SETUP;
                 end
        P_SETUP: st <= P_HIGH;
        P_HIGH:  if (take) begin
                   data_q <= in_data;
                   st     <= P_SETUP;
                 end else st <= P_IDLE;
        default: st <= P_IDLE;
      endcase
    end
  end

  AST_CLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |=> !cfg_clk); // R7
  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_data)); // R7
endmodule

// File: rtl/cfgld_gap_timer.sv
module cfgld_gap_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] period,
  input  logic          run,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= period;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/cfgport_loader.sv
module cfgport_loader import cfgld_pkg::*; #(
  parameter int ARG_W = 16,
  parameter int DW    = 8,
  parameter int OW    = 2,
  parameter int MY_ID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             hd_valid,
  output logic             hd_ready,
  input  logic [DW-1:0]    hd_data,
  output logic             fl_req,
  input  logic [OW-1:0]    fl_owner,
  output logic [ARG_W-1:0] fl_addr,
  output logic             fl_rd,
  input  logic [DW-1:0]    fl_data,
  input  logic             fl_dvalid,
  output logic [DW-1:0]    cfg_data,
  output logic             cfg_wr,
  output logic             cfg_cs,
  output logic             cfg_clk,
  output logic             busy
);
  localparam logic [ARG_W-1:0] ONE = ARG_W'(1);

  top_st_e          st;
  op_e              op;
  logic [ARG_W-1:0] first_q, last_q, count_q, period_q, rem_q;
  logic             scrub_q;
  logic             take_cmd, abort_now, start_fl, gap_done, gap_load;
  logic             fr_valid, fr_ready, fr_done;
  logic [DW-1:0]    fr_data;
  logic             drv_valid, drv_ready, drv_idle;
  logic [DW-1:0]    drv_data;
  logic             in_session;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (st == T_IDLE) || (op == OP_ABORT);
  assign take_cmd  = cmd_valid && cmd_ready;
  assign abort_now = take_cmd && (op == OP_ABORT);
  assign start_fl  = ((st == T_IDLE) && take_cmd &&
                      (op == OP_RUN_FLASH || op == OP_RUN_SCRUB)) ||
                     ((st == T_GAP) && gap_done && !abort_now);
  assign gap_load  = (st == T_DRAIN) && drv_idle && scrub_q;

  assign in_session = (st == T_FLASH) || (st == T_HOST) || (st == T_DRAIN);
  assign cfg_cs     = in_session;
  assign cfg_wr     = in_session;
  assign busy       = (st != T_IDLE);

  assign drv_valid = (st == T_FLASH) ? fr_valid : ((st == T_HOST) ? hd_valid : 1'b0);
  assign drv_data  = (st == T_FLASH) ? fr_data : hd_data;
  assign fr_ready  = (st == T_FLASH) && drv_ready;
  assign hd_ready  = (st == T_HOST) && drv_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      first_q  <= '0;
      last_q   <= '0;
      count_q  <= '0;
      period_q <= '0;
      rem_q    <= '0;
      scrub_q  <= 1'b0;
    end else if (abort_now) begin
      st      <= T_IDLE;
      scrub_q <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (take_cmd) begin
          case (op)
            OP_SET_FIRST: first_q <= cmd_arg;
            OP_SET_LAST:  last_q  <= cmd_arg;
            OP_SET_COUNT: count_q <= cmd_arg;
            OP_RUN_FLASH: begin scrub_q <= 1'b0; st <= T_FLASH; end
            OP_RUN_SCRUB: begin period_q <= cmd_arg; scrub_q <= 1'b1; st <= T_FLASH; end
            OP_RUN_HOST:  if (count_q != '0) begin rem_q <= count_q; st <= T_HOST; end
            default: ;
          endcase
        end
        T_FLASH: if (fr_done) st <= T_DRAIN;
        T_HOST:  if (hd_valid && hd_ready) begin
                   rem_q <= rem_q - 1'b1;
                   if (rem_q == ONE) st <= T_DRAIN;
                 end
        T_DRAIN: if (drv_idle) st <= scrub_q ? T_GAP : T_IDLE;
        T_GAP:   if (gap_done) st <= T_FLASH;
        default: st <= T_IDLE;
      endcase
    end
  end

  cfgld_flash_rd #(.AW(ARG_W), .DW(DW), .OW(OW), .MY_ID(MY_ID)) u_flash (
    .clk(clk), .rst_n(rst_n), .start(start_fl), .abort(abort_now),
    .first_addr(first_q), .last_addr(last_q),
    .fl_req(fl_req), .fl_owner(fl_owner), .fl_addr(fl_addr), .fl_rd(fl_rd),
    .fl_data(fl_data), .fl_dvalid(fl_dvalid),
    .out_valid(fr_valid), .out_ready(fr_ready), .out_data(fr_data), .done(fr_done)
  );

  cfgld_port_drv #(.DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n), .flush(abort_now),
    .in_valid(drv_valid), .in_ready(drv_ready), .in_data(drv_data),
    .cfg_data(cfg_data), .cfg_clk(cfg_clk), .idle(drv_idle)
  );

  cfgld_gap_timer #(.CW(ARG_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .period(period_q),
    .run(st == T_GAP), .expired(gap_done)
  );

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> (!cfg_cs && !cfg_wr && !cfg_clk && !fl_req && !busy)); // R10
  AST_CLK_IN_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> (cfg_cs && cfg_wr)); // R8
  AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk); // R11
  AST_HOST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hd_ready |-> busy); // R6
endmodule

// File: tb/tb_cfgport_loader.sv
module tb_cfgport_loader;
  localparam int AW = 8;
  localparam int ID = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_arg = '0;
  logic          hd_valid = 1'b0;
  logic          hd_ready;
  logic [7:0]    hd_data = 8'd0;
  logic          fl_req;
  logic [1:0]    fl_owner;
  logic [AW-1:0] fl_addr;
  logic          fl_rd;
  logic [7:0]    fl_data;
  logic          fl_dvalid;
  logic [7:0]    cfg_data;
  logic          cfg_wr, cfg_cs, cfg_clk, busy;

  int vec = 0;
  int mis = 0;
  int edges = 0;
  int cyc = 0;
  int last_cyc = 0;
  int max_gap = 0;
  int rd_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  cfgport_loader #(.ARG_W(AW), .DW(8), .OW(2), .MY_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .hd_valid(hd_valid), .hd_ready(hd_ready),
    .hd_data(hd_data), .fl_req(fl_req), .fl_owner(fl_owner), .fl_addr(fl_addr),
    .fl_rd(fl_rd), .fl_data(fl_data), .fl_dvalid(fl_dvalid), .cfg_data(cfg_data),
    .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_clk(cfg_clk), .busy(busy)
  );

  function automatic logic [7:0] fdat(input logic [AW-1:0] a);
    return 8'(int'(a) * 29 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      mis++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic push_range(input int a, input int b);
    for (int i = a; i <= b; i++) exp_q.push_back(fdat(AW'(i)));
  endtask

  task automatic send_host(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(8'(8'hC0 + i * 3));
      @(negedge clk);
      hd_valid = 1'b1; hd_data = 8'(8'hC0 + i * 3);
      while (!hd_ready) @(negedge clk);
      @(negedge clk);
      hd_valid = 1'b0;
      repeat (i % 3) @(negedge clk);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // flash model: another user (code 1) shown until the grant delay passes
  initial begin
    int gcnt; int lat; bit pend; logic [AW-1:0] la;
    gcnt = 0; lat = 0; pend = 0; la = '0;
    fl_owner = 2'd1; fl_dvalid = 1'b0; fl_data = 8'd0;
    forever begin
      @(posedge clk);
      fl_dvalid <= 1'b0;
      if (!fl_req) begin gcnt = 0; fl_owner <= 2'd1; end
      else if (gcnt < 3) gcnt++;
      else fl_owner <= 2'(ID);
      if (pend) begin
        if (lat == 0) begin fl_dvalid <= 1'b1; fl_data <= fdat(la); pend = 0; end
        else lat--;
      end
      if (fl_rd) begin
        rd_cnt++;
        chk(fl_owner == 2'(ID), "R4 read issued without ownership", int'(fl_owner), ID);
        la = fl_addr; lat = int'(fl_addr % 3); pend = 1;
      end
    end
  end

  // scoreboard monitor
  initial begin
    logic prev; logic [7:0] e;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (cfg_clk && !prev) begin
        edges++;
        if (cyc - last_cyc > max_gap) max_gap = cyc - last_cyc;
        last_cyc = cyc;
        if (exp_q.size() == 0) chk(1'b0, "R7 clock pulse with no byte due", edges, 0);
        else begin
          e = exp_q.pop_front();
          chk(cfg_data == e, "R3/R6 byte order", int'(cfg_data), int'(e));
        end
        chk(cfg_cs && cfg_wr, "R8 select and strobe on pulse", int'({cfg_cs, cfg_wr}), 3);
      end
      prev = cfg_clk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    int base; int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !cfg_cs && !cfg_wr && !cfg_clk, "R1 outputs idle", int'({busy, cfg_cs, cfg_wr, cfg_clk}), 0);
    chk(!fl_req && !hd_ready, "R1 no request", int'({fl_req, hd_ready}), 0);
    chk(cmd_ready, "R1 command ready", int'(cmd_ready), 1);

    // R2 R3 R4 R5: range 5..9, reserved code in between
    send_cmd(3'd0, 8'd5);
    send_cmd(3'd1, 8'd9);
    send_cmd(3'd7, 8'd0);
    chk(!busy, "R2 reserved code starts nothing", int'(busy), 0);
    base = edges; r0 = rd_cnt;
    push_range(5, 9);
    send_cmd(3'd2, 8'd0);
    chk(busy, "R11 busy after run", int'(busy), 1);
    wait_idle();
    chk(edges - base == 5, "R3 inclusive range count", edges - base, 5);
    chk(rd_cnt - r0 == 5, "R4 one read per address", rd_cnt - r0, 5);
    chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
    chk(!fl_req, "R5 request dropped", int'(fl_req), 0);

    // R3 last below first
    send_cmd(3'd0, 8'd20);
    send_cmd(3'd1, 8'd18);
    base = edges;
    push_range(20, 20);
    send_cmd(3'd2, 8'd0);
    wait_idle();
    chk(edges - base == 1, "R3 reversed range gives one byte", edges - base, 1);

    // R6 R7 host bytes with uneven gaps
    send_cmd(3'd3, 8'd4);
    base = edges;
    send_cmd(3'd4, 8'd0);
    send_host(4);
    wait_idle();
    chk(edges - base == 4, "R6 exact count clocked", edges - base, 4);
    chk(!cfg_cs && !cfg_wr, "R8 released after transfer", int'({cfg_cs, cfg_wr}), 0);
    @(negedge clk);
    hd_valid = 1'b1; hd_data = 8'hEE;
    #1;
    chk(!hd_ready, "R6 extra host byte refused", int'(hd_ready), 0);
    repeat (5) @(negedge clk);
    hd_valid = 1'b0;
    chk(edges - base == 4, "R6 extra byte not clocked", edges - base, 4);

    // R6 count zero
    send_cmd(3'd3, 8'd0);
    send_cmd(3'd4, 8'd0);
    chk(!busy, "R6 zero count starts nothing", int'(busy), 0);

    // R11 busy refuses commands, R10 abort mid-pass
    send_cmd(3'd0, 8'd0);
    send_cmd(3'd1, 8'd40);
    base = edges;
    push_range(0, 40);
    send_cmd(3'd2, 8'd0);
    while (edges < base + 2) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    #1;
    chk(busy && !cmd_ready, "R11 run refused while busy", int'(cmd_ready), 0);
    cmd_valid = 1'b0;
    while (edges < base + 5) @(negedge clk);
    send_cmd(3'd6, 8'd0);
    chk(!cfg_cs && !cfg_wr && !cfg_clk, "R10 port quiet after abort", int'({cfg_cs, cfg_wr, cfg_clk}), 0);
    chk(!fl_req && !busy, "R10 request and busy dropped", int'({fl_req, busy}), 0);
    base = edges;
    repeat (30) @(negedge clk);
    chk(edges == base, "R10 no pulse after abort", edges - base, 0);
    exp_q.delete();

    // R9 scrub range 3..6 with period 20
    send_cmd(3'd0, 8'd3);
    send_cmd(3'd1, 8'd6);
    base = edges;
    push_range(3, 6); push_range(3, 6); push_range(3, 6);
    send_cmd(3'd5, 8'd20);
    while (edges < base + 1) @(negedge clk);
    max_gap = 0;
    while (edges < base + 4) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy && !cfg_cs && !cfg_wr, "R8 R9 released in scrub gap", int'({busy, cfg_cs, cfg_wr}), 4);
    while (edges < base + 12) @(negedge clk);
    chk(max_gap > 20, "R9 gap exceeds period", max_gap, 21);
    send_cmd(3'd6, 8'd0);
    chk(!busy && !fl_req, "R10 scrub stopped", int'({busy, fl_req}), 0);
    repeat (60) @(negedge clk);
    chk(edges == base + 12, "R9 three passes then stop", edges - base, 12);
    chk(exp_q.size() == 0, "R9 passes repeat range", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule